// File: doc/BRIEF.md
# Dual-Channel Programmable Reload Timer

This peripheral gives a small 8-bit processor system two independent 16-bit down-counters. Each channel has a running count and a 16-bit reload value. The reload value is written one byte at a time over an 8-bit I/O port. A free-running prescaler produces a timer tick once every 20 system clocks. On each tick, an enabled channel that has reached zero reloads itself and raises its interrupt flag; otherwise it counts down by one. The ticks have no gating input, so counting goes on while the processor is halted.

One shared control byte holds three things for each channel: a count-enable bit, an interrupt-enable bit and a read-only flag. Turning a channel's enable on forces its counter to zero, so the first tick after that reloads the counter and raises the flag. Software clears a flag in two steps: it reads the control byte, then reads either counter byte of that channel. Reading the counter's low byte captures the high byte, so the two halves that software sees come from the same instant.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset every counter and every reload register reads 16'hFFFF, and the control byte reads 8'h00 (all enables, interrupt enables and flags are 0).
- R2: On a tick, an enabled channel whose counter is zero loads its reload value and sets its flag. An enabled channel whose counter is not zero decrements its counter by one.
- R3: A control write that changes a channel's enable from 0 to 1 clears that channel's counter to zero. The next tick then reloads the counter and sets the flag.
- R4: A channel whose enable bit is 0 keeps its counter value and never sets its flag.
- R5: The control byte at address 8 has this layout: bit 7 is the channel 1 flag, bit 6 the channel 0 flag, bit 5 the channel 1 interrupt enable, bit 4 the channel 0 interrupt enable, bits 3:2 are spare storage, bit 1 is the channel 1 enable and bit 0 the channel 0 enable. A write updates only bits 5:0 (mask 8'h3F), so the flags cannot be written.
- R6: Output irq[n] is high exactly while the interrupt enable and the flag of channel n are both 1.
- R7: A read of the control byte, followed later by a read of channel n's counter low byte or high byte, clears flag n. The clear is cancelled if a tick sets flag n in the same cycle. A counter read without the preceding control read leaves the flag unchanged.
- R8: Reading a counter's low byte captures its high byte. The next read of the high byte returns the captured value, even if the counter has moved since the low byte was read.
- R9: The tick occurs once every 20 clocks. The prescaler starts from zero at reset, so the first tick falls on the 20th clock after reset. Nothing stops the prescaler.
- R10: The register map is as follows. Channel n occupies addresses 4n to 4n+3: counter low byte (read only), counter high byte (read only), reload low byte and reload high byte. Both reload bytes can be written and read back. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 4 | Register address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, one cycle per read (side effects apply at the clock edge) |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the current address, combinational |
| irq | output | 2 | Per-channel interrupt requests |

## Verification
If a counter or the prescaler phase is wrong, the error appears in the next counter-byte read. It also shifts the cycle at which the flag rises, and the following control read or irq sample shows that shift within one tick period (20 clocks). Corrupted flag-clear bookkeeping shows as a flag that stays high, or clears when it should not, in the control read right after the counter read that should have armed or fired the clear. A fault in the high-byte capture shows only when the counter crosses a byte boundary between the low and high reads, so the bench arranges exactly that crossing. The collision between a clear and a new flag is hit on purpose in the single cycle where a tick lands.

// File: rtl/drt_pkg.sv
package drt_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      SLOT_CNT_LO = 2'd0,
      SLOT_CNT_HI = 2'd1,
      SLOT_RLD_LO = 2'd2,
      SLOT_RLD_HI = 2'd3
   } slot_e;
endpackage

// File: rtl/drt_prescaler.sv
module drt_prescaler #(
   parameter int DIV = 20
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   initial assert (DIV >= 1) else $error("drt_prescaler: DIV must be at least 1");

   generate
      if (DIV == 1) begin : g_pass
         assign tick = 1'b1;
      end else begin : g_div
         localparam int PW = $clog2(DIV);
         logic [PW-1:0] pcnt;

         assign tick = (pcnt == PW'(DIV - 1));

         always_ff @(posedge clk) begin
            if (!rst_n)    pcnt <= '0;
            else if (tick) pcnt <= '0;
            else           pcnt <= pcnt + 1'b1;
         end

         AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            pcnt <= PW'(DIV - 1));                              // R9
         AST_PRE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> (pcnt == '0));                             // R9
      end
   endgenerate
endmodule

// File: rtl/drt_channel.sv
module drt_channel #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             en,
   input  logic             en_rise,
   input  logic             rld_lo_we,
   input  logic             rld_hi_we,
   input  logic [7:0]       wdata,
   input  logic             rd_lo,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] rld,
   output logic [7:0]       hi_latch,
   output logic             flag
);
   localparam int HALF = CNT_W / 2;

   initial assert (CNT_W == 2 * drt_pkg::BYTE_W)
      else $error("drt_channel: counter must be exactly two bytes wide");

   logic at_zero;
   logic set_flag;

   assign at_zero  = (cnt == '0);
   assign set_flag = en & tick & at_zero;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '1;
      end else if (en_rise) begin
         cnt <= '0;
      end else if (en && tick) begin
         cnt <= at_zero ? rld : cnt - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (set_flag) begin
         flag <= 1'b1;
      end else if (flag_clr) begin
         flag <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rld <= '1;
      end else begin
         if (rld_lo_we) rld[HALF-1:0]     <= wdata;
         if (rld_hi_we) rld[CNT_W-1:HALF] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     hi_latch <= '1;
      else if (rd_lo) hi_latch <= cnt[CNT_W-1:HALF];
   end

   AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && at_zero && !en_rise) |=> (cnt == $past(rld)) && flag);   // R2
   AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && !at_zero && !en_rise) |=> (cnt == $past(cnt) - 1'b1));  // R2
   AST_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      en_rise |=> (cnt == '0));                                             // R3
   AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !en_rise) |=> $stable(cnt));                                  // R4
   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (set_flag && flag_clr) |=> flag);                                     // R7
   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !set_flag) |=> !flag);                                   // R7
endmodule

// File: rtl/drt_ctrl.sv
module drt_ctrl #(
   parameter int         NCH   = 2,
   parameter logic [7:0] WMASK = 8'h3F
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr,
   input  logic           rd,
   input  logic [7:0]     wdata,
   input  logic [NCH-1:0] flags,
   input  logic [NCH-1:0] cnt_rd,
   output logic [NCH-1:0] en,
   output logic [NCH-1:0] ie,
   output logic [NCH-1:0] en_rise,
   output logic [NCH-1:0] clr,
   output logic [7:0]     ctrl_byte
);
   localparam int IE_LSB   = 4;
   localparam int FLAG_LSB = 6;

   initial assert (NCH == 2) else $error("drt_ctrl: layout is defined for two channels");

   logic [7:0]     wr_q;
   logic [NCH-1:0] arm;

   assign en        = wr_q[NCH-1:0];
   assign ie        = wr_q[IE_LSB +: NCH];
   assign en_rise   = {NCH{wr}} & wdata[NCH-1:0] & ~en;
   assign clr       = arm & cnt_rd;
   assign ctrl_byte = (wr_q & WMASK) | ({flags, {FLAG_LSB{1'b0}}} & ~WMASK);

   always_ff @(posedge clk) begin
      if (!rst_n)  wr_q <= '0;
      else if (wr) wr_q <= (wr_q & ~WMASK) | (wdata & WMASK);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  arm <= '0;
      else if (rd) arm <= flags;
      else         arm <= arm & ~cnt_rd;
   end

   AST_MASKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> ((ctrl_byte & WMASK) == ($past(wdata) & WMASK)));             // R5
   AST_RISE_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
      (|en_rise) |=> ((en & $past(en_rise)) == $past(en_rise)));            // R3
   AST_ARM_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr && !rd) |=> ((arm & $past(clr)) == '0));                        // R7
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
   import drt_pkg::*;
#(
   parameter int NCH     = 2,
   parameter int CNT_W   = 16,
   parameter int PRE_DIV = 20,
   parameter int ADDR_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   output logic [NCH-1:0]    irq
);
   localparam int CTRL_ADDR = 4 * NCH;
   localparam int HALF      = CNT_W / 2;

   initial assert ((1 << ADDR_W) > CTRL_ADDR)
      else $error("dual_reload_timer: address too narrow for the map");

   logic                 tick;
   logic                 ctrl_sel;
   slot_e                slot;
   logic [NCH-1:0]       hit;
   logic [NCH-1:0]       en, ie, en_rise, clr, flag, cnt_rd;
   logic [7:0]           ctrl_byte;
   logic [CNT_W-1:0]     cnt      [NCH];
   logic [CNT_W-1:0]     rld      [NCH];
   logic [7:0]           hi_latch [NCH];

   assign ctrl_sel = (io_addr == ADDR_W'(CTRL_ADDR));
   assign slot     = slot_e'(io_addr[1:0]);

   drt_prescaler #(.DIV(PRE_DIV)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   drt_ctrl #(.NCH(NCH)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (io_wr & ctrl_sel),
      .rd        (io_rd & ctrl_sel),
      .wdata     (io_wdata),
      .flags     (flag),
      .cnt_rd    (cnt_rd),
      .en        (en),
      .ie        (ie),
      .en_rise   (en_rise),
      .clr       (clr),
      .ctrl_byte (ctrl_byte)
   );

   generate
      for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
         assign hit[ch]    = (io_addr[ADDR_W-1:2] == (ADDR_W-2)'(ch));
         assign cnt_rd[ch] = io_rd & hit[ch] &
                             ((slot == SLOT_CNT_LO) || (slot == SLOT_CNT_HI));
         assign irq[ch]    = ie[ch] & flag[ch];

         drt_channel #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .en        (en[ch]),
            .en_rise   (en_rise[ch]),
            .rld_lo_we (io_wr & hit[ch] & (slot == SLOT_RLD_LO)),
            .rld_hi_we (io_wr & hit[ch] & (slot == SLOT_RLD_HI)),
            .wdata     (io_wdata),
            .rd_lo     (io_rd & hit[ch] & (slot == SLOT_CNT_LO)),
            .flag_clr  (clr[ch]),
            .cnt       (cnt[ch]),
            .rld       (rld[ch]),
            .hi_latch  (hi_latch[ch]),
            .flag      (flag[ch])
         );
      end
   endgenerate

   always_comb begin
      io_rdata = '0;
      if (ctrl_sel) io_rdata = ctrl_byte;
      for (int ch = 0; ch < NCH; ch++) begin
         if (hit[ch]) begin
            unique case (slot)
               SLOT_CNT_LO: io_rdata = cnt[ch][HALF-1:0];
               SLOT_CNT_HI: io_rdata = hi_latch[ch];
               SLOT_RLD_LO: io_rdata = rld[ch][HALF-1:0];
               SLOT_RLD_HI: io_rdata = rld[ch][CNT_W-1:HALF];
            endcase
         end
      end
   end

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (irq & ~flag) == '0);                                                 // R6
   AST_FLAG_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !en_rise) |=> ((flag & ~$past(flag)) == '0));               // R2
endmodule

// File: tb/sim_dual_reload_timer.sv
`timescale 1ns/1ps
module sim_dual_reload_timer;
   localparam int DIV  = 20;
   localparam int CTRL = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] io_addr = '0;
   logic       io_wr = 1'b0;
   logic       io_rd = 1'b0;
   logic [7:0] io_wdata = '0;
   logic [7:0] io_rdata;
   logic [1:0] irq;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   dual_reload_timer u0 (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .irq(irq)
   );

   // ---------------- reference model built from the requirements ----------------
   int          m_pre;
   logic [15:0] m_cnt   [2];
   logic [15:0] m_rld   [2];
   logic [7:0]  m_latch [2];
   logic [1:0]  m_flag, m_arm, m_en, m_ie, m_spare;

   always @(posedge clk) begin
      bit          tk;
      bit          set, clr;
      logic [15:0] o_cnt [2];
      logic [15:0] o_rld [2];
      logic [1:0]  o_flag, o_arm, o_en;
      int          b;
      if (!rst_n) begin
         m_pre = 0;
         for (int c = 0; c < 2; c++) begin
            m_cnt[c] = 16'hFFFF; m_rld[c] = 16'hFFFF; m_latch[c] = 8'hFF;
         end
         m_flag = '0; m_arm = '0; m_en = '0; m_ie = '0; m_spare = '0;
      end else begin
         tk = (m_pre == DIV - 1);
         m_pre = tk ? 0 : m_pre + 1;
         o_flag = m_flag; o_arm = m_arm; o_en = m_en;
         for (int c = 0; c < 2; c++) begin
            o_cnt[c] = m_cnt[c]; o_rld[c] = m_rld[c];
         end
         for (int c = 0; c < 2; c++) begin
            b = 4 * c;
            set = 1'b0;
            if (io_wr && io_addr == CTRL && io_wdata[c] && !o_en[c]) begin
               m_cnt[c] = '0;
            end else if (o_en[c] && tk) begin
               if (o_cnt[c] == 0) begin m_cnt[c] = o_rld[c]; set = 1'b1; end
               else m_cnt[c] = o_cnt[c] - 1;
            end
            if (io_rd && io_addr == b) m_latch[c] = o_cnt[c][15:8];
            clr = o_arm[c] && io_rd && (io_addr == b || io_addr == b + 1);
            if (set) m_flag[c] = 1'b1;
            else if (clr) m_flag[c] = 1'b0;
            if (io_rd && io_addr == CTRL) m_arm[c] = o_flag[c];
            else if (io_rd && (io_addr == b || io_addr == b + 1)) m_arm[c] = 1'b0;
            if (io_wr && io_addr == b + 2) m_rld[c][7:0]  = io_wdata;
            if (io_wr && io_addr == b + 3) m_rld[c][15:8] = io_wdata;
         end
         if (io_wr && io_addr == CTRL) begin
            m_en = io_wdata[1:0]; m_spare = io_wdata[3:2]; m_ie = io_wdata[5:4];
         end
      end
   end

   function automatic logic [7:0] model_read(input logic [3:0] a);
      int c;
      if (a == CTRL) return {m_flag[1], m_flag[0], m_ie, m_spare, m_en};
      if (a >= CTRL) return 8'h00;
      c = a / 4;
      case (a % 4)
         0: return m_cnt[c][7:0];
         1: return m_latch[c];
         2: return m_rld[c][7:0];
         default: return m_rld[c][15:8];
      endcase
   endfunction

   // ---------------- scoreboard ----------------
   typedef struct {
      logic [7:0] v;
      string      tag;
   } exp_t;
   exp_t exp_q[$];
   event mon_ev;

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   initial forever begin
      exp_t e;
      @(mon_ev);
      if (exp_q.size() > 0) begin
         e = exp_q.pop_front();
         chk(io_rdata, e.v, e.tag);
      end
   end

   // ---------------- driver ----------------
   task automatic read_now(input logic [3:0] a, input string tag);
      exp_t e;
      io_addr = a; io_rd = 1'b1; io_wr = 1'b0;
      e.v = model_read(a); e.tag = tag;
      exp_q.push_back(e);
      #1; ->mon_ev;
      @(negedge clk); io_rd = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input string tag);
      @(negedge clk);
      read_now(a, tag);
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1; io_rd = 1'b0;
      @(negedge clk); io_wr = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_irq(input string tag);
      @(negedge clk); #1;
      chk({6'b0, irq}, {6'b0, m_ie & m_flag}, tag);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      wait_cyc(4);
      @(negedge clk); rst_n = 1'b1;

      // R1 reset state, R10 map
      rd(CTRL, "R1 ctrl after reset");
      rd(0, "R1 cnt0 lo after reset");
      rd(1, "R1 cnt0 hi after reset");
      rd(6, "R1 R10 rld1 lo after reset");
      rd(7, "R1 R10 rld1 hi after reset");
      rd(4'd12, "R10 unmapped reads zero");
      chk_irq("R1 irq after reset");

      // R5 flags are not writable
      wr(CTRL, 8'hC0);
      rd(CTRL, "R5 flag bits ignored on write");
      wr(CTRL, 8'h0C);
      rd(CTRL, "R5 spare bits stored");
      wr(CTRL, 8'h00);

      // R10 reload write and read back
      wr(2, 8'h03); wr(3, 8'h00);
      rd(2, "R10 rld0 lo");
      rd(3, "R10 rld0 hi");

      // R3 enable rise clears, R2 reload/decrement, R9 tick spacing
      wr(CTRL, 8'h01);
      rd(0, "R3 cnt0 cleared on enable");
      wait_cyc(30);
      rd(CTRL, "R2 R3 flag0 after first tick");
      rd(0, "R2 R9 cnt0 after reload");
      rd(4, "R4 cnt1 holds while off");
      rd(5, "R4 cnt1 hi holds while off");
      wait_cyc(25);
      rd(0, "R2 R9 cnt0 decrement");

      // R6 interrupt request
      wr(CTRL, 8'h11);
      chk_irq("R6 irq0 with flag and enable");

      // R7 two-step clear
      rd(CTRL, "R7 arm read");
      rd(0, "R7 clearing read");
      rd(CTRL, "R7 flag0 cleared");
      chk_irq("R6 R7 irq0 drops after clear");

      // R7 counter read without arm keeps flag
      wait_cyc(90);
      rd(CTRL, "R2 flag0 set again");
      rd(1, "R7 unarmed-first read clears after arm");
      wait_cyc(85);
      rd(1, "R7 read without ctrl read");
      rd(CTRL, "R7 flag0 kept without arm");
      chk_irq("R6 irq0 still high");

      // R7 collision: clear and set in the same cycle
      wr(2, 8'h00); wr(3, 8'h00);
      wait_cyc(45);
      rd(CTRL, "R7 arm before collision");
      @(negedge clk);
      while (m_pre != DIV - 1) @(negedge clk);
      read_now(0, "R7 counter read on tick cycle");
      rd(CTRL, "R7 flag0 survives collision");
      chk_irq("R6 R7 irq0 after collision");

      // R8 high byte capture across a byte boundary
      wr(6, 8'h00); wr(7, 8'h01);
      wr(CTRL, 8'h13);
      @(negedge clk);
      while (m_cnt[1] != 16'h0100) @(negedge clk);
      read_now(4, "R8 cnt1 lo at 0100");
      wait_cyc(DIV + 2);
      rd(5, "R8 cnt1 hi returns captured byte");
      rd(4, "R8 R2 cnt1 lo after crossing");
      rd(5, "R8 cnt1 hi recaptured");

      // R4 hold when disabled, R3 re-enable clears
      wr(CTRL, 8'h11);
      rd(4, "R4 cnt1 at disable");
      wait_cyc(50);
      rd(4, "R4 cnt1 unchanged while off");
      rd(CTRL, "R4 flag1 not set while off");
      wr(CTRL, 8'h13);
      rd(4, "R3 cnt1 cleared on re-enable");
      wait_cyc(DIV + 1);
      rd(CTRL, "R3 flag1 after re-enable tick");
      rd(4, "R3 R9 cnt1 reloaded");

      wait_cyc(2);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule